// File: doc/BRIEF.md
# SECDED-Protected Banked Memory Channel

This block is a single-clock on-chip memory channel holding 72-bit words: 64 data bits and 8 check bits. It has a write port and a read port that work independently. Each port has its own address and an active-low enable. On a write, an internal single-error-correct, double-error-detect encoder produces the check bits. On a read, a decoder checks the stored word, repairs a single flipped bit and raises detect and correct flags. The repair is applied only to the returned word and is never written back to the array.

Two run-time controls open up the check field. The encoder bypass stores caller-supplied check bits, which lets software plant known errors. The decoder bypass returns the stored check bits untouched and keeps both flags quiet. The address space is divided into equal banks. Only the first `BANKS_EN` banks exist, and requests above them are dropped. An active-low shutdown input turns the channel off. While it is low, every request is ignored and stored contents are lost.

Top module: `ecc_mem_chan`

## Requirements
- R1: A write is performed only at a rising edge where `wr_en_n` is 0, `sd_n` is 1 and `rst` is 0. A read is accepted only at a rising edge where `rd_en_n` is 0, `sd_n` is 1 and `rst` is 0. Without an accepted read, `rd_q` and the flags do not change to new results.
- R2: Read data appears on `rd_q` one clock after the read is accepted. `err_det` and `err_cor` are aligned with that data and stay high for that single cycle only.
- R3: Stored word layout is data in [63:0] and check bits in [71:64]. The data bits occupy Hamming positions 3..71, in ascending order, skipping powers of two. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of data[63:0] and check[6:0].
- R4: With `enc_byp` = 1 at the write, `wr_data[71:64]` is stored as the check bits. With `enc_byp` = 0, the R3 encoder supplies them.
- R5: With `dec_byp` = 1 at the read, `rd_q` is the raw stored 72-bit word, and `err_det` and `err_cor` stay 0.
- R6: A word with exactly one flipped bit returns fully repaired data and check bits, with `err_det` = 1 and `err_cor` = 1.
- R7: A word with two flipped bits returns its stored data bits unchanged, with `err_det` = 1 and `err_cor` = 0.
- R8: A repaired read does not modify the array, so re-reading the same address raises the same flags again.
- R9: Address bits above log2(`BANK_WORDS`) select the bank and the low bits select the word. A write to a bank numbered `BANKS_EN` or above changes no stored word.
- R10: While `sd_n` = 0, read and write requests are ignored and both flags are 0. After wake-up, contents are undefined until rewritten, and a rewritten word reads back correctly.
- R11: A read and a write to the same address in the same cycle return the word stored before that write.
- R12: After reset, `rd_q` is all zeros and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_n | input | 1 | Write request, active low |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | 72 | Write data; [71:64] used only under encoder bypass |
| enc_byp | input | 1 | Store `wr_data[71:64]` as check bits |
| rd_en_n | input | 1 | Read request, active low |
| rd_addr | input | ADDR_W | Read word address |
| dec_byp | input | 1 | Return the raw stored word, no checking |
| sd_n | input | 1 | Channel shutdown, active low |
| rd_q | output | 72 | Read word (repaired, or raw under bypass) |
| err_det | output | 1 | Error found on the read word |
| err_cor | output | 1 | Error found and repaired |

## Verification
The bench builds the channel with 16-word banks, 4 bank slots and 3 populated banks, which gives a 6-bit address. This size makes the highest populated bank and the missing fourth bank both reachable with a handful of writes. Errors are planted through the encoder bypass, in check bits and in data bits, as both single and double faults. This exercises the repair paths, the detect-only path and the no-write-back rule without needing any fault-injection hook inside the design.

// File: rtl/ecc_chan_pkg.sv
package ecc_chan_pkg;

  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int LAST_POS = DATA_W + HAM_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HAM_W-1:0]  syn_t;

  function automatic logic is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  // XOR of the Hamming positions of all set data bits
  function automatic syn_t pos_xor(input data_t d);
    syn_t acc;
    int   k;
    acc = '0;
    k   = 0;
    for (int pos = 1; pos <= LAST_POS; pos++) begin
      if (!is_pow2(pos)) begin
        if (d[k]) acc = acc ^ syn_t'(pos);
        k++;
      end
    end
    return acc;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_chan_pkg::*;
(
  input  data_t data,
  output chk_t  chk
);

  syn_t ham;

  always_comb begin
    ham = pos_xor(data);
    chk = {(^data) ^ (^ham), ham};
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_chan_pkg::*;
(
  input  word_t code,
  output word_t fixed,
  output logic  single,
  output logic  double
);

  syn_t syn;
  logic odd;

  always_comb begin
    int k;
    syn    = pos_xor(code[DATA_W-1:0]) ^ code[DATA_W +: HAM_W];
    odd    = ^code;
    fixed  = code;
    single = 1'b0;
    double = 1'b0;
    k      = 0;
    if (odd) begin
      if (syn == '0) begin
        fixed[WORD_W-1] = ~code[WORD_W-1];
        single = 1'b1;
      end else if (int'(syn) > LAST_POS) begin
        double = 1'b1;
      end else begin
        single = 1'b1;
        for (int i = 0; i < HAM_W; i++) begin
          if (int'(syn) == (1 << i)) fixed[DATA_W+i] = ~code[DATA_W+i];
        end
        for (int pos = 1; pos <= LAST_POS; pos++) begin
          if (!is_pow2(pos)) begin
            if (int'(syn) == pos) fixed[k] = ~code[k];
            k++;
          end
        end
      end
    end else if (syn != '0) begin
      double = 1'b1;
    end
  end

endmodule

// File: rtl/ecc_bank_store.sv
module ecc_bank_store #(
  parameter int BANK_WORDS = 64,
  parameter int BANKS_EN   = 3,
  parameter int ADDR_W     = 8,
  parameter int WORD_W     = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int OFF_W = $clog2(BANK_WORDS);
  localparam int SEL_W = ADDR_W - OFF_W;

  logic [SEL_W-1:0] wsel, rsel, rsel_q;
  logic [OFF_W-1:0] woff, roff;
  logic             rhit_q;
  logic [WORD_W-1:0] bank_q [BANKS_EN];

  assign wsel = waddr[ADDR_W-1:OFF_W];
  assign woff = waddr[OFF_W-1:0];
  assign rsel = raddr[ADDR_W-1:OFF_W];
  assign roff = raddr[OFF_W-1:0];

  for (genvar b = 0; b < BANKS_EN; b++) begin : g_bank
    logic [WORD_W-1:0] mem [BANK_WORDS];
    logic [WORD_W-1:0] q_r;
    always_ff @(posedge clk) begin
      if (we && wsel == SEL_W'(b)) mem[woff] <= wdata;
      if (re && rsel == SEL_W'(b)) q_r <= mem[roff];
    end
    assign bank_q[b] = q_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rhit_q <= 1'b0;
      rsel_q <= '0;
    end else if (re) begin
      rhit_q <= {1'b0, rsel} < (SEL_W+1)'(BANKS_EN);
      rsel_q <= rsel;
    end
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < BANKS_EN; b++) begin
      if (rhit_q && rsel_q == SEL_W'(b)) rdata = bank_q[b];
    end
  end

endmodule

// File: rtl/ecc_mem_chan.sv
module ecc_mem_chan
  import ecc_chan_pkg::*;
#(
  parameter int BANK_WORDS = 64,
  parameter int MAX_BANKS  = 4,
  parameter int BANKS_EN   = 3,
  parameter int ADDR_W     = $clog2(BANK_WORDS) + $clog2(MAX_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [71:0]       wr_data,
  input  logic              enc_byp,
  input  logic              rd_en_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              dec_byp,
  input  logic              sd_n,
  output logic [71:0]       rd_q,
  output logic              err_det,
  output logic              err_cor
);

  logic  wr_go, rd_go;
  chk_t  gen_chk, use_chk;
  word_t raw, fixed;
  logic  single, double;
  logic  vld_q, byp_q;

  assign wr_go = !wr_en_n && sd_n && !rst;
  assign rd_go = !rd_en_n && sd_n && !rst;

  secded_enc u_enc (
    .data (wr_data[DATA_W-1:0]),
    .chk  (gen_chk)
  );

  assign use_chk = enc_byp ? wr_data[WORD_W-1:DATA_W] : gen_chk;

  ecc_bank_store #(
    .BANK_WORDS (BANK_WORDS),
    .BANKS_EN   (BANKS_EN),
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata ({use_chk, wr_data[DATA_W-1:0]}),
    .re    (rd_go),
    .raddr (rd_addr),
    .rdata (raw)
  );

  secded_dec u_dec (
    .code   (raw),
    .fixed  (fixed),
    .single (single),
    .double (double)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      byp_q <= 1'b0;
    end else begin
      vld_q <= rd_go;
      if (rd_go) byp_q <= dec_byp;
    end
  end

  assign rd_q    = byp_q ? raw : fixed;
  assign err_det = vld_q && !byp_q && (single || double);
  assign err_cor = vld_q && !byp_q && single;

endmodule

// File: rtl/ecc_mem_chan_chk.sv
module ecc_mem_chan_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd_en_n,
  input logic        dec_byp,
  input logic        sd_n,
  input logic [71:0] rd_q,
  input logic        err_det,
  input logic        err_cor
);

  p_cor_has_det_r6: assert property (@(posedge clk) disable iff (rst)
    err_cor |-> err_det);

  p_flag_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    err_det |-> $past(!rd_en_n && sd_n));

  p_byp_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rd_en_n && sd_n && dec_byp) |-> (!err_det && !err_cor));

  p_sd_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!sd_n) |-> (!err_det && !err_cor));

  p_hold_no_read_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en_n || !sd_n) |-> $stable(rd_q));

endmodule

bind ecc_mem_chan ecc_mem_chan_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en_n (rd_en_n),
  .dec_byp (dec_byp),
  .sd_n    (sd_n),
  .rd_q    (rd_q),
  .err_det (err_det),
  .err_cor (err_cor)
);

// File: tb/ecc_mem_chan_test.sv
module ecc_mem_chan_test;

  localparam int BW = 16, MB = 4, BE = 3;
  localparam int AW = $clog2(BW) + $clog2(MB);

  logic          clk = 1'b0, rst = 1'b1;
  logic          wr_en_n = 1'b1, rd_en_n = 1'b1, enc_byp = 1'b0, dec_byp = 1'b0, sd_n = 1'b1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [71:0]   wr_data = '0, rd_q;
  logic          err_det, err_cor;
  int            n_run = 0, n_fail = 0;
  logic [71:0]   q_s;
  logic          det_s, cor_s;

  always #4 clk = ~clk;

  ecc_mem_chan #(.BANK_WORDS(BW), .MAX_BANKS(MB), .BANKS_EN(BE)) uut (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .enc_byp(enc_byp), .rd_en_n(rd_en_n), .rd_addr(rd_addr), .dec_byp(dec_byp),
    .sd_n(sd_n), .rd_q(rd_q), .err_det(err_det), .err_cor(err_cor));

  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] p = '0;
    int pos = 3;
    for (int j = 0; j < 64; j++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      if (d[j]) p = p ^ 7'(pos);
      pos++;
    end
    return {^{d, p}, p};
  endfunction

  function automatic logic [71:0] cw(input logic [63:0] d);
    return {ref_chk(d), d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [73:0] act, input logic [73:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [71:0] d, input logic byp);
    @(negedge clk);
    wr_en_n = 1'b0; wr_addr = a; wr_data = d; enc_byp = byp;
    @(negedge clk);
    wr_en_n = 1'b1; enc_byp = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic byp);
    @(negedge clk);
    rd_en_n = 1'b0; rd_addr = a; dec_byp = byp;
    @(negedge clk);
    rd_en_n = 1'b1; dec_byp = 1'b0;
    q_s = rd_q; det_s = err_det; cor_s = err_cor;
  endtask

  task automatic t_reset;
    check(rd_q == '0 && !err_det && !err_cor, "R12", {err_det, err_cor, rd_q}, '0);
  endtask

  task automatic t_basic;
    logic [63:0] pats [4] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_0F0F_1234_5678, 64'h8000_0000_0000_0001};
    for (int i = 0; i < 4; i++) wr(AW'(i * 13), {8'h00, pats[i]}, 1'b0);
    for (int i = 0; i < 4; i++) begin
      rd(AW'(i * 13), 1'b0);
      check(q_s == cw(pats[i]) && !det_s, "R3", {det_s, cor_s, q_s}, {2'b00, cw(pats[i])});
    end
    @(negedge clk);
    check(!err_det && !err_cor && rd_q == cw(pats[3]), "R2", {err_det, err_cor, rd_q}, {2'b00, cw(pats[3])});
  endtask

  task automatic t_single;
    logic [63:0] d = 64'h0123_4567_89AB_CDEF;
    logic [63:0] d2 = d ^ 64'h20;
    wr(6'd7, {ref_chk(d) ^ 8'h04, d}, 1'b1);
    rd(7, 1'b1);
    check(q_s == {ref_chk(d) ^ 8'h04, d} && !det_s && !cor_s, "R4", {det_s, cor_s, q_s}, {2'b00, ref_chk(d) ^ 8'h04, d});
    check(!det_s && !cor_s, "R5", {det_s, cor_s, 72'h0}, '0);
    rd(7, 1'b0);
    check(q_s == cw(d) && det_s && cor_s, "R6", {det_s, cor_s, q_s}, {2'b11, cw(d)});
    rd(7, 1'b0);
    check(det_s && cor_s, "R8", {det_s, cor_s, q_s}, {2'b11, cw(d)});
    wr(6'd8, {ref_chk(d2), d}, 1'b1);
    rd(8, 1'b0);
    check(q_s == cw(d2) && det_s && cor_s, "R6", {det_s, cor_s, q_s}, {2'b11, cw(d2)});
  endtask

  task automatic t_double;
    logic [63:0] d = 64'hDEAD_BEEF_0BAD_F00D;
    wr(6'd9, {ref_chk(d) ^ 8'h03, d}, 1'b1);
    rd(9, 1'b0);
    check(q_s[63:0] == d && det_s && !cor_s, "R7", {det_s, cor_s, q_s}, {2'b10, 8'h00, d});
  endtask

  task automatic t_enables;
    logic [63:0] d = 64'h1111_2222_3333_4444;
    wr(6'd40, {8'h0, d}, 1'b0);
    @(negedge clk);
    wr_addr = 6'd40; wr_data = 72'h0FFFF; wr_en_n = 1'b1;
    @(negedge clk);
    rd(40, 1'b0);
    check(q_s == cw(d), "R1", {det_s, cor_s, q_s}, {2'b00, cw(d)});
    @(negedge clk);
    rd_addr = 6'd7; rd_en_n = 1'b1;
    @(negedge clk);
    check(rd_q == cw(d) && !err_det, "R1", {err_det, err_cor, rd_q}, {2'b00, cw(d)});
  endtask

  task automatic t_range;
    logic [63:0] d = 64'h5555_AAAA_5555_AAAA;
    wr(6'd5, {8'h0, d}, 1'b0);
    wr(6'(3 * BW + 5), {8'h0, ~d}, 1'b0);
    rd(5, 1'b0);
    check(q_s == cw(d), "R9", {det_s, cor_s, q_s}, {2'b00, cw(d)});
  endtask

  task automatic t_rdw;
    logic [63:0] d = 64'hCAFE_0000_BABE_0001;
    wr(6'd20, {8'h0, d}, 1'b0);
    @(negedge clk);
    wr_en_n = 1'b0; rd_en_n = 1'b0; wr_addr = 6'd20; rd_addr = 6'd20; wr_data = 72'h77;
    @(negedge clk);
    wr_en_n = 1'b1; rd_en_n = 1'b1;
    check(rd_q == cw(d), "R11", {err_det, err_cor, rd_q}, {2'b00, cw(d)});
    rd(20, 1'b0);
    check(rd_q == cw(64'h77), "R11", {err_det, err_cor, rd_q}, {2'b00, cw(64'h77)});
  endtask

  task automatic t_shutdown;
    logic [63:0] d = 64'h0F0F_F0F0_1357_9BDF;
    logic [71:0] held;
    wr(6'd7, {ref_chk(d) ^ 8'h01, d}, 1'b1);
    rd(7, 1'b0);
    held = q_s;
    @(negedge clk);
    sd_n = 1'b0;
    rd_en_n = 1'b0; rd_addr = 6'd7;
    @(negedge clk);
    check(!err_det && !err_cor && rd_q == held, "R10", {err_det, err_cor, rd_q}, {2'b00, held});
    rd_en_n = 1'b1;
    @(negedge clk);
    sd_n = 1'b1;
    wr(6'd7, {8'h0, d}, 1'b0);
    rd(7, 1'b0);
    check(q_s == cw(d) && !det_s, "R10", {det_s, cor_s, q_s}, {2'b00, cw(d)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_basic;
    t_single;
    t_double;
    t_enables;
    t_range;
    t_rdw;
    t_shutdown;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule